// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Sequencer

This block is the device-side controller of a byte-wide nonvolatile memory with a 15-bit address. A host drives chip-select, write-strobe and read-enable lines (all active low), which the block samples on its own clock. Each qualified write strobe deposits one byte into a 64-byte page buffer. The first byte of a burst fixes the page, and later bytes may arrive at any offset in any order. When the strobe stays quiet for a set number of cycles, the load window closes. The block then runs a timed internal write cycle that commits the whole page to the array. Offsets that were never loaded are written with a filler byte.

While the write cycle runs, `busy` is high. Reads return a polling status word instead of array data, and all write strobes are dropped. The array is a synchronous RAM model. It backs the lowest `2**ARR_PG_W` pages. Commits to higher pages are discarded, and reads of those pages return the filler byte.

Top module: `pgwr_seq`

## Requirements
- R1: Outside the write cycle, a read (`cs_n`=0, `oe_n`=0, `we_n`=1 on a clock edge) puts the stored byte on `dout` with `dout_en`=1 after that same edge. Reads of pages at or above `2**ARR_PG_W` return FILL. In any cycle without a read, `dout`=0 and `dout_en`=0. Both are 0 after reset.
- R2: A write strobe is active only while `cs_n`=0, `we_n`=0 and `oe_n`=1. Holding `oe_n` low blocks every load.
- R3: A strobe that stays active for fewer than MIN_PULSE sampled cycles is discarded and does not open a load window.
- R4: The page (address bits 14..6) is taken from the first load of a window. Each load writes the byte at its own offset (bits 5..0), and loads may come in any order.
- R5: A load takes its address from the first active cycle of its strobe. It takes its data from the first sampled cycle after the strobe ends.
- R6: `busy` rises exactly TMO_CYC clock edges after the edge on which the last load completed, provided no further strobe becomes active in between.
- R7: `busy` stays high for exactly WR_CYC cycles. Strobes issued while it is high change nothing. It is 0 after reset.
- R8: After the write cycle, every offset of the page that was not loaded in the window reads as FILL (default 8'hFF).
- R9: A read during the write cycle returns a status word. Bit 7 is the inverse of bit 7 of the last loaded byte, and bits 5..0 are 0.
- R10: In the status word, bit 6 flips from each read in the write cycle to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read enable, active low |
| addr | input | ADDR_W | Byte address, page in bits 14..6 |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status, registered |
| dout_en | output | 1 | High when `dout` carries a read result |
| busy | output | 1 | Internal write cycle in progress |

## Verification
On every cycle, the assertions check the read latency and the idle value of the outputs, the zero bits and the alternating bit of the status word, the exact length of the busy interval, and that no load reaches the page buffer while the write cycle runs. Other behaviours can only be shown by the bench's scenarios, because they depend on what ends up stored in the array. These are loading out of order, capturing the address at the start of the strobe and the data at its end, filling unloaded offsets, the exact timeout edge, and the rejection of short pulses, of writes with read-enable low and of strobes issued while busy.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int OFF_W    = 6;
  localparam int PG_BYTES = 1 << OFF_W;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_BUSY
  } seq_st_e;
endpackage

// File: rtl/wsq_strobe.sv
module wsq_strobe #(
  parameter int ADDR_W    = 15,
  parameter int MIN_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_act,
  output logic              ld_fire,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [7:0]        ld_data
);
  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] MINV = CW'(MIN_PULSE);

  logic              act_q;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_en;

  assign wr_act  = en & ~cs_n & ~we_n & oe_n;
  assign addr_en = wr_act & ~act_q;

  always_comb begin
    cnt_d = cnt_q;
    if (addr_en)
      cnt_d = CW'(1);
    else if (wr_act && (cnt_q < MINV))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      act_q <= wr_act;
      cnt_q <= cnt_d;
      if (addr_en)
        addr_q <= addr;
    end
  end

  assign ld_fire = ~wr_act & act_q & (cnt_q >= MINV);
  assign ld_addr = addr_q;
  assign ld_data = din;
endmodule

// File: rtl/wsq_pagebuf.sv
module wsq_pagebuf
  import pgwr_pkg::*;
#(
  parameter int          ADDR_W = 15,
  parameter logic [7:0]  FILL   = 8'hFF,
  localparam int         PG_W   = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_fire,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              clr,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic              win_open,
  output logic [PG_W-1:0]   page,
  output logic              last7,
  output logic [7:0]        rd_byte
);
  logic [7:0]          bytes_q [PG_BYTES];
  logic [PG_BYTES-1:0] mask_q;
  logic [PG_W-1:0]     page_q;
  logic                last7_q;
  logic [OFF_W-1:0]    off;

  assign off      = ld_addr[OFF_W-1:0];
  assign win_open = |mask_q;

  always_ff @(posedge clk) begin
    if (ld_fire)
      bytes_q[off] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      page_q  <= '0;
      last7_q <= 1'b0;
    end else begin
      if (clr)
        mask_q <= '0;
      else if (ld_fire)
        mask_q[off] <= 1'b1;
      if (ld_fire && !win_open)
        page_q <= ld_addr[ADDR_W-1:OFF_W];
      if (ld_fire)
        last7_q <= ld_data[7];
    end
  end

  assign page    = page_q;
  assign last7   = last7_q;
  assign rd_byte = mask_q[rd_idx] ? bytes_q[rd_idx] : FILL;
endmodule

// File: rtl/wsq_ctrl.sv
module wsq_ctrl
  import pgwr_pkg::*;
#(
  parameter int TMO_CYC = 7500,
  parameter int WR_CYC  = 500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_fire,
  input  logic             win_open,
  input  logic             wr_act,
  output logic             busy,
  output logic             commit_we,
  output logic [OFF_W-1:0] commit_idx,
  output logic             clr
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int WW = $clog2(WR_CYC + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);
  localparam logic [WW-1:0] WR_LAST  = WW'(WR_CYC - 1);
  localparam logic [WW-1:0] WR_PAGE  = WW'(PG_BYTES);

  seq_st_e       st_q, st_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic [WW-1:0] wr_q, wr_d;

  always_comb begin
    st_d  = st_q;
    tmo_d = tmo_q;
    wr_d  = wr_q;
    clr   = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (ld_fire)
          tmo_d = '0;
        else if (win_open && !wr_act) begin
          if (tmo_q == TMO_LAST) begin
            st_d  = SEQ_BUSY;
            tmo_d = '0;
            wr_d  = '0;
          end else
            tmo_d = tmo_q + 1'b1;
        end
      end
      default: begin
        if (wr_q == WR_LAST) begin
          st_d = SEQ_IDLE;
          clr  = 1'b1;
        end else
          wr_d = wr_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      tmo_q <= '0;
      wr_q  <= '0;
    end else begin
      st_q  <= st_d;
      tmo_q <= tmo_d;
      wr_q  <= wr_d;
    end
  end

  assign busy       = (st_q == SEQ_BUSY);
  assign commit_we  = busy && (wr_q < WR_PAGE);
  assign commit_idx = wr_q[OFF_W-1:0];
endmodule

// File: rtl/wsq_array.sv
module wsq_array
  import pgwr_pkg::*;
#(
  parameter int         ADDR_W   = 15,
  parameter int         ARR_PG_W = 4,
  parameter logic [7:0] FILL     = 8'hFF,
  localparam int        PG_W     = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PG_W-1:0]   wr_page,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic              last7,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int IW    = ARR_PG_W + OFF_W;
  localparam int DEPTH = 1 << IW;

  logic [7:0]    mem [DEPTH];
  logic          wr_hit, rd_hit;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [7:0]    dout_q, dout_d;
  logic          den_q, tog_q, tog_d;

  generate
    if (ARR_PG_W < PG_W) begin : g_part
      assign wr_hit = ~|wr_page[PG_W-1:ARR_PG_W];
      assign rd_hit = ~|rd_addr[ADDR_W-1:IW];
    end else begin : g_full
      assign wr_hit = 1'b1;
      assign rd_hit = 1'b1;
    end
  endgenerate

  assign wr_idx = {wr_page[ARR_PG_W-1:0], wr_off};
  assign rd_idx = rd_addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (wr_en && wr_hit)
      mem[wr_idx] <= wr_data;
  end

  always_comb begin
    tog_d = tog_q;
    if (!rd_en)
      dout_d = 8'h00;
    else if (busy) begin
      dout_d = {~last7, tog_q, 6'b0};
      tog_d  = ~tog_q;
    end else if (!rd_hit)
      dout_d = FILL;
    else
      dout_d = mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 8'h00;
      den_q  <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      den_q  <= rd_en;
      tog_q  <= tog_d;
    end
  end

  assign dout    = dout_q;
  assign dout_en = den_q;
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int         ADDR_W    = 15,
  parameter int         ARR_PG_W  = 4,
  parameter int         MIN_PULSE = 2,
  parameter int         TMO_CYC   = 7500,
  parameter int         WR_CYC    = 500000,
  parameter logic [7:0] FILL      = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              busy
);
  localparam int PG_W = ADDR_W - OFF_W;

  logic              wr_act, ld_fire, rd_en;
  logic [ADDR_W-1:0] ld_addr;
  logic [7:0]        ld_data, rd_byte;
  logic              win_open, last7, clr, commit_we;
  logic [PG_W-1:0]   page;
  logic [OFF_W-1:0]  commit_idx;

  assign rd_en = ~cs_n & ~oe_n & we_n;

  wsq_strobe #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) i_strobe (
    .clk(clk), .rst_n(rst_n), .en(~busy), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .wr_act(wr_act),
    .ld_fire(ld_fire), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  wsq_pagebuf #(.ADDR_W(ADDR_W), .FILL(FILL)) i_pagebuf (
    .clk(clk), .rst_n(rst_n), .ld_fire(ld_fire), .ld_addr(ld_addr),
    .ld_data(ld_data), .clr(clr), .rd_idx(commit_idx),
    .win_open(win_open), .page(page), .last7(last7), .rd_byte(rd_byte)
  );

  wsq_ctrl #(.TMO_CYC(TMO_CYC), .WR_CYC(WR_CYC)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_fire(ld_fire), .win_open(win_open),
    .wr_act(wr_act), .busy(busy), .commit_we(commit_we),
    .commit_idx(commit_idx), .clr(clr)
  );

  wsq_array #(.ADDR_W(ADDR_W), .ARR_PG_W(ARR_PG_W), .FILL(FILL)) i_array (
    .clk(clk), .rst_n(rst_n), .wr_en(commit_we), .wr_page(page),
    .wr_off(commit_idx), .wr_data(rd_byte), .rd_en(rd_en), .rd_addr(addr),
    .busy(busy), .last7(last7), .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk #(
  parameter int WR_CYC = 500000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       busy,
  input logic [7:0] dout,
  input logic       dout_en,
  input logic       ld_fire
);
  logic        rd;
  logic [31:0] bcnt;

  assign rd = ~cs_n & ~oe_n & we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bcnt <= '0;
    else if (busy)
      bcnt <= bcnt + 1'b1;
    else
      bcnt <= '0;
  end

  // R1
  read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> dout_en);

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (!dout_en && dout == 8'h00));

  // R9
  poll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy) |=> (dout[5:0] == 6'd0));

  // R10
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy && $past(rd && busy)) |=> (dout[6] != $past(dout[6])));

  // R7
  no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_fire);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == 32'(WR_CYC)));
endmodule

bind pgwr_seq pgwr_seq_chk #(.WR_CYC(WR_CYC)) i_pgwr_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
  .busy(busy), .dout(dout), .dout_en(dout_en), .ld_fire(ld_fire)
);

// File: tb/test_pgwr_seq.sv
module test_pgwr_seq;
  localparam int TMO = 12;
  localparam int WR  = 100;
  localparam int MINP = 2;
  localparam logic [7:0] FILLV = 8'hFF;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, we_n, oe_n;
  logic [14:0] addr;
  logic [7:0]  din, dout;
  logic        dout_en, busy;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] msk;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   total = 0;
  int   bad = 0;
  bit   tb_tog = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pgwr_seq #(.MIN_PULSE(MINP), .TMO_CYC(TMO), .WR_CYC(WR), .FILL(FILLV)) i_pgwr_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per produced read result
  exp_t cur;
  always @(negedge clk) begin
    if (rst_n && dout_en) begin
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected read result actual=%0h expected=none", dout);
      end else begin
        cur = sbq.pop_front();
        if ((dout & cur.msk) !== (cur.exp & cur.msk)) begin
          bad++;
          $display("FAIL %s actual=%0h expected=%0h", cur.tag, dout & cur.msk, cur.exp & cur.msk);
        end
      end
    end
  end

  task automatic read_one(input logic [14:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    it.exp = e; it.msk = 8'hFF; it.tag = tag;
    addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    sbq.push_back(it);
    @(negedge clk);
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic busy_read(input logic [14:0] a, input bit last7, input string tag);
    logic [7:0] e;
    e = {~last7, tb_tog, 6'b0};
    tb_tog = ~tb_tog;
    read_one(a, e, tag);
  endtask

  task automatic wr_byte(input logic [14:0] a, input logic [7:0] d, input int ncyc, input bit oe);
    addr = a; din = d; cs_n = 1'b0; we_n = 1'b0; oe_n = oe;
    repeat (ncyc) @(negedge clk);
    we_n = 1'b1; cs_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < WR + 10 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [14:0] base;
    int used;
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R7 busy after reset", busy, 0);
    chk(dout_en == 1'b0, "R1 dout_en after reset", dout_en, 0);
    chk(dout == 8'h00, "R1 dout after reset", dout, 0);

    // R4: page 3, offsets loaded out of order
    base = 15'h00C0;
    wr_byte(base + 15'd5,  8'h81, 2, 1'b1);
    wr_byte(base + 15'd2,  8'h42, 3, 1'b1);
    wr_byte(base + 15'd63, 8'hC7, 2, 1'b1);
    wr_byte(base + 15'd0,  8'h3C, 2, 1'b1);
    // R6: exact timeout edge
    repeat (TMO - 1) @(negedge clk);
    chk(busy == 1'b0, "R6 busy one cycle before timeout", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R6 busy at timeout", busy, 1);
    // R9 / R10: polling status
    busy_read(base, 1'b0, "R9 status bit7 complement");
    busy_read(base, 1'b0, "R10 status bit6 toggles");
    busy_read(base, 1'b0, "R10 status bit6 toggles again");
    used = 3;
    // R7: write attempt while busy is dropped
    wr_byte(base + 15'd2, 8'h99, 3, 1'b1);
    used += 4;
    repeat (WR - 1 - used) @(negedge clk);
    chk(busy == 1'b1, "R7 busy on last cycle", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R7 busy ends after WR cycles", busy, 0);

    read_one(base + 15'd5,  8'h81, "R4 offset 5");
    read_one(base + 15'd2,  8'h42, "R7 offset 2 unchanged by busy write");
    read_one(base + 15'd63, 8'hC7, "R4 offset 63");
    read_one(base + 15'd0,  8'h3C, "R4 offset 0");
    read_one(base + 15'd1,  FILLV, "R8 unloaded offset 1");
    read_one(base + 15'd40, FILLV, "R8 unloaded offset 40");
    read_one(15'h4000 | base, FILLV, "R1 unbacked page reads filler");
    @(negedge clk);
    chk(dout == 8'h00 && dout_en == 1'b0, "R1 outputs idle without read", {dout, 7'b0, dout_en}, 0);

    // R3: short pulse ignored
    wr_byte(15'h0140, 8'h11, 1, 1'b1);
    repeat (TMO + 4) @(negedge clk);
    chk(busy == 1'b0, "R3 short pulse opens no window", busy, 0);

    // R2: read-enable low inhibits writes
    wr_byte(15'h0140, 8'h22, 3, 1'b0);
    repeat (TMO + 4) @(negedge clk);
    chk(busy == 1'b0, "R2 oe low inhibits load", busy, 0);

    // R5: address at strobe start, data at strobe end
    base = 15'h0180;
    addr = base + 15'd7; din = 8'h00; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    addr = base + 15'd9; din = 8'hA5;
    repeat (2) @(negedge clk);
    we_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    repeat (TMO) @(negedge clk);
    chk(busy == 1'b1, "R6 second window times out", busy, 1);
    busy_read(base + 15'd7, 1'b1, "R9 status bit7 for set bit");
    wait_idle();
    read_one(base + 15'd7, 8'hA5, "R5 address from strobe start");
    read_one(base + 15'd9, FILLV, "R5 later address not used");
    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R1 all reads answered", sbq.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule